// File: doc/BRIEF.md
# Shift Unit with Carry Selection

This block is the shifter of a 32-bit compact-encoding integer datapath. It moves an operand left or right, arithmetically right, or rotates it right. The shift amount comes either from a 5-bit field held in the instruction or from the low byte of a register. Alongside the shifted value it computes the new carry flag, the negative and zero flags, and a per-flag write enable. The overflow flag passes through unchanged. The unit is purely combinational, so it sits between register read and write-back and adds no cycle.

The two amount sources follow different rules at the edges. An immediate of zero means "shift by the full word" for the logical-right and arithmetic-right kinds. A register amount of zero is a true no-op that leaves the carry alone. Register amounts of 32 and above each get their own carry rule rather than being masked down.

Top module: `shift_carry_unit`

## Requirements
- R1: Shift kind encoding is 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. The amount is taken from `reg_amt_i` when `use_reg_i` is 1 and from `imm_amt_i` otherwise. When the amount is zero (any register amount of 0, or an immediate 0 with kind 0 or 3), the result equals the operand, `carry_o` equals `carry_i` and `flag_we_o[1]` is 0.
- R2: Logical left by k in 1..31 (either source) gives operand << k, and carry is operand bit (32-k).
- R3: Logical right or arithmetic right by k in 1..31 gives the logically or sign-filled shifted value, and carry is operand bit (k-1).
- R4: An immediate amount of 0 with logical right gives result 0 and carry equal to operand bit 31. With arithmetic right it gives 32 copies of bit 31, and carry equal to bit 31.
- R5: A register logical left of exactly 32 gives result 0 and carry equal to bit 0. A register logical right of exactly 32 gives result 0 and carry equal to bit 31. Both kinds give result 0 and carry 0 for register amounts from 33 to 255.
- R6: A register arithmetic right of 32 or more fills the result with bit 31 and sets carry to bit 31.
- R7: Rotate right uses the amount modulo 32 as r. If r is nonzero, the operand is rotated by r and carry is operand bit (r-1). If the amount is a nonzero multiple of 32, the operand is returned unchanged and carry is bit 31.
- R8: `neg_o` is result bit 31, `zero_o` is 1 exactly when the result is 0, and `ovf_o` equals `ovf_i`. `flag_we_o` bits are {3: N, 2: Z, 1: C, 0: V}. N and Z are always 1, V is always 0, and C is 1 whenever the amount is not zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Operand to be shifted |
| kind_i | input | 2 | Shift kind (encoding in R1) |
| use_reg_i | input | 1 | 1 selects the register amount, 0 the immediate |
| imm_amt_i | input | 5 | Immediate shift amount |
| reg_amt_i | input | 8 | Low byte of the amount register |
| carry_i | input | 1 | Current carry flag |
| ovf_i | input | 1 | Current overflow flag |
| result_o | output | 32 | Shifted value |
| carry_o | output | 1 | New carry flag |
| neg_o | output | 1 | Result bit 31 |
| zero_o | output | 1 | Result equals zero |
| ovf_o | output | 1 | Overflow flag, passed through |
| flag_we_o | output | 4 | Write enables for N, Z, C, V |

## Verification
The carry choice and the N/Z update both act on the same evaluation. When the amount resolves to a no-op or to a whole-word rotate, the carry must come from the old flag or from bit 31 while N and Z are still taken from the unchanged result. The bench provokes this by sending register amounts 0, 32 and 255 and immediate 0 through every kind. It uses operands whose bit 31, bit 0 and the incoming carry all differ, so that any wrong source is visible. For every applied vector the scoreboard predicts the result, the carry and the four flag outputs, and compares them on the following falling edge.

// File: rtl/shf_pkg.sv
package shf_pkg;
   typedef enum logic [1:0] {
      SK_LSL = 2'd0,
      SK_LSR = 2'd1,
      SK_ASR = 2'd2,
      SK_ROR = 2'd3
   } shift_kind_e;
endpackage

// File: rtl/shf_amount_norm.sv
module shf_amount_norm
   import shf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 5,
   parameter int REG_W  = 8,
   localparam int LOG_W = $clog2(DATA_W),
   localparam int AMT_W = $clog2(DATA_W + 2)
) (
   input  shift_kind_e        kind_i,
   input  logic               use_reg_i,
   input  logic [IMM_W-1:0]   imm_amt_i,
   input  logic [REG_W-1:0]   reg_amt_i,
   output logic [AMT_W-1:0]   amt_sat_o,
   output logic [LOG_W-1:0]   rot_amt_o,
   output logic               noop_o
);
   localparam logic [REG_W-1:0] WORD_LIM = REG_W'(DATA_W);

   if (IMM_W > REG_W) begin : g_bad_imm
      $error("immediate amount wider than register amount");
   end
   if (REG_W < AMT_W) begin : g_bad_reg
      $error("register amount cannot express saturation");
   end

   logic [REG_W-1:0] raw;
   logic             full_imm;

   always_comb begin
      raw       = use_reg_i ? reg_amt_i : REG_W'(imm_amt_i);
      full_imm  = !use_reg_i && (imm_amt_i == '0) &&
                  (kind_i == SK_LSR || kind_i == SK_ASR);
      noop_o    = (raw == '0) && !full_imm;
      rot_amt_o = raw[LOG_W-1:0];
      if (full_imm)
         amt_sat_o = AMT_W'(DATA_W);
      else if (raw > WORD_LIM)
         amt_sat_o = AMT_W'(DATA_W + 1);
      else
         amt_sat_o = raw[AMT_W-1:0];
   end
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel
   import shf_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int LOG_W = $clog2(DATA_W),
   localparam int AMT_W = $clog2(DATA_W + 2)
) (
   input  logic [DATA_W-1:0] opnd_i,
   input  shift_kind_e       kind_i,
   input  logic [AMT_W-1:0]  amt_sat_i,
   input  logic [LOG_W-1:0]  rot_amt_i,
   output logic [DATA_W-1:0] res_o,
   output logic              cout_o
);
   if ((1 << LOG_W) != DATA_W) begin : g_bad_width
      $error("data width must be a power of two");
   end

   logic [DATA_W-1:0] rev_in, rev_out, sh_word;
   logic [DATA_W:0]   base;
   logic              fill;

   // bit reversal lets the left shift reuse the right-shift stages
   for (genvar b = 0; b < DATA_W; b++) begin : g_rev
      assign rev_in[b]  = opnd_i[DATA_W-1-b];
      assign rev_out[b] = sh_word[DATA_W-1-b];
   end

   assign fill = (kind_i == SK_ASR) & opnd_i[DATA_W-1];
   assign base = {((kind_i == SK_LSL) ? rev_in : opnd_i), 1'b0};

   // right-shift stages over an extended word; bit 0 collects the carry
   for (genvar i = 0; i < AMT_W; i++) begin : g_sh
      localparam int SH = 1 << i;
      logic [DATA_W:0] prv, nxt;
      if (i == 0) begin : g_first
         assign prv = base;
      end else begin : g_rest
         assign prv = g_sh[i-1].nxt;
      end
      if (SH >= DATA_W + 1) begin : g_flood
         assign nxt = amt_sat_i[i] ? {(DATA_W+1){fill}} : prv;
      end else begin : g_part
         assign nxt = amt_sat_i[i] ? {{SH{fill}}, prv[DATA_W:SH]} : prv;
      end
   end

   assign sh_word = g_sh[AMT_W-1].nxt[DATA_W:1];

   // rotate stages
   for (genvar j = 0; j < LOG_W; j++) begin : g_rot
      localparam int RS = 1 << j;
      logic [DATA_W-1:0] prv, nxt;
      if (j == 0) begin : g_first
         assign prv = opnd_i;
      end else begin : g_rest
         assign prv = g_rot[j-1].nxt;
      end
      assign nxt = rot_amt_i[j] ? {prv[RS-1:0], prv[DATA_W-1:RS]} : prv;
   end

   always_comb begin
      if (kind_i == SK_ROR) begin
         res_o  = g_rot[LOG_W-1].nxt;
         cout_o = g_rot[LOG_W-1].nxt[DATA_W-1];
      end else begin
         res_o  = (kind_i == SK_LSL) ? rev_out : sh_word;
         cout_o = g_sh[AMT_W-1].nxt[0];
      end
   end

   always_comb begin
      if ((kind_i == SK_LSL || kind_i == SK_LSR) && int'(amt_sat_i) > DATA_W)
         a_r5_over_word_clears : assert (res_o == '0 && !cout_o)
            else $error("R5: shift beyond word left bits behind");
      if (kind_i == SK_ASR && int'(amt_sat_i) >= DATA_W)
         a_r6_sign_flood : assert (res_o == {DATA_W{opnd_i[DATA_W-1]}} &&
                                   cout_o == opnd_i[DATA_W-1])
            else $error("R6: arithmetic shift did not flood sign");
      if (kind_i == SK_LSL && amt_sat_i != '0 && int'(amt_sat_i) < DATA_W)
         a_r2_left_carry_bit : assert (cout_o == opnd_i[DATA_W - int'(amt_sat_i)])
            else $error("R2: left shift carry from wrong bit");
      if (kind_i == SK_ROR && rot_amt_i == '0)
         a_r7_whole_turn : assert (res_o == opnd_i)
            else $error("R7: whole-word rotate changed operand");
   end
endmodule

// File: rtl/shf_flags.sv
module shf_flags #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] res_i,
   input  logic              cout_i,
   input  logic              noop_i,
   input  logic              carry_i,
   input  logic              ovf_i,
   output logic              carry_o,
   output logic              neg_o,
   output logic              zero_o,
   output logic              ovf_o,
   output logic [3:0]        we_o
);
   always_comb begin
      carry_o = noop_i ? carry_i : cout_i;
      neg_o   = res_i[DATA_W-1];
      zero_o  = (res_i == '0);
      ovf_o   = ovf_i;
      we_o    = {1'b1, 1'b1, ~noop_i, 1'b0};
   end

   always_comb begin
      if (zero_o)
         a_r8_zero_not_negative : assert (!neg_o)
            else $error("R8: zero and negative both set");
   end
endmodule

// File: rtl/shift_carry_unit.sv
module shift_carry_unit
   import shf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 5,
   parameter int REG_W  = 8
) (
   input  logic [DATA_W-1:0] opnd_i,
   input  logic [1:0]        kind_i,
   input  logic              use_reg_i,
   input  logic [IMM_W-1:0]  imm_amt_i,
   input  logic [REG_W-1:0]  reg_amt_i,
   input  logic              carry_i,
   input  logic              ovf_i,
   output logic [DATA_W-1:0] result_o,
   output logic              carry_o,
   output logic              neg_o,
   output logic              zero_o,
   output logic              ovf_o,
   output logic [3:0]        flag_we_o
);
   localparam int LOG_W = $clog2(DATA_W);
   localparam int AMT_W = $clog2(DATA_W + 2);

   shift_kind_e      kind;
   logic [AMT_W-1:0] amt_sat;
   logic [LOG_W-1:0] rot_amt;
   logic             noop, cout;

   assign kind = shift_kind_e'(kind_i);

   shf_amount_norm #(.DATA_W(DATA_W), .IMM_W(IMM_W), .REG_W(REG_W)) u_norm (
      .kind_i    (kind),
      .use_reg_i (use_reg_i),
      .imm_amt_i (imm_amt_i),
      .reg_amt_i (reg_amt_i),
      .amt_sat_o (amt_sat),
      .rot_amt_o (rot_amt),
      .noop_o    (noop)
   );

   shf_barrel #(.DATA_W(DATA_W)) u_barrel (
      .opnd_i    (opnd_i),
      .kind_i    (kind),
      .amt_sat_i (amt_sat),
      .rot_amt_i (rot_amt),
      .res_o     (result_o),
      .cout_o    (cout)
   );

   shf_flags #(.DATA_W(DATA_W)) u_flags (
      .res_i   (result_o),
      .cout_i  (cout),
      .noop_i  (noop),
      .carry_i (carry_i),
      .ovf_i   (ovf_i),
      .carry_o (carry_o),
      .neg_o   (neg_o),
      .zero_o  (zero_o),
      .ovf_o   (ovf_o),
      .we_o    (flag_we_o)
   );

   always_comb begin
      if (noop)
         a_r1_noop_passes_operand : assert (result_o == opnd_i && !flag_we_o[1])
            else $error("R1: zero amount altered operand");
   end
endmodule

// File: tb/sim_shift_carry_unit.sv
module sim_shift_carry_unit;
   timeunit 1ns; timeprecision 100ps;

   typedef struct {
      logic [31:0] res;
      logic        c, n, z, v;
      logic [3:0]  we;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] opnd = '0;
   logic [1:0]  kind = '0;
   logic        use_reg = 1'b0;
   logic [4:0]  imm = '0;
   logic [7:0]  ramt = '0;
   logic        cin = 1'b0, vin = 1'b0;
   logic [31:0] result;
   logic        cout, neg, zero, vout;
   logic [3:0]  we;

   int   checks = 0, errors = 0;
   bit   done = 1'b0;
   exp_t sb[$];

   always #2.5 clk = ~clk;

   shift_carry_unit u0 (
      .opnd_i(opnd), .kind_i(kind), .use_reg_i(use_reg), .imm_amt_i(imm),
      .reg_amt_i(ramt), .carry_i(cin), .ovf_i(vin), .result_o(result),
      .carry_o(cout), .neg_o(neg), .zero_o(zero), .ovf_o(vout), .flag_we_o(we)
   );

   function automatic exp_t predict(input logic [1:0] k, input bit ur, input logic [4:0] im,
                                    input logic [7:0] ra, input logic [31:0] x,
                                    input bit ci, input bit vi);
      exp_t e;
      int   n, m;
      n = ur ? int'(ra) : int'(im);
      e.tag = "R1";
      if (!ur && im == 0 && (k == 2'd1 || k == 2'd2)) n = 32;
      if (n == 0) begin
         e.res = x; e.c = ci;
      end else begin
         case (k)
            2'd0: if (n < 32) begin e.res = x << n; e.c = x[32-n]; e.tag = "R2"; end
                  else if (n == 32) begin e.res = '0; e.c = x[0]; e.tag = "R5"; end
                  else begin e.res = '0; e.c = 1'b0; e.tag = "R5"; end
            2'd1: if (n < 32) begin e.res = x >> n; e.c = x[n-1]; e.tag = "R3"; end
                  else if (n == 32) begin e.res = '0; e.c = x[31]; e.tag = ur ? "R5" : "R4"; end
                  else begin e.res = '0; e.c = 1'b0; e.tag = "R5"; end
            2'd2: if (n < 32) begin e.res = 32'($signed(x) >>> n); e.c = x[n-1]; e.tag = "R3"; end
                  else begin e.res = {32{x[31]}}; e.c = x[31]; e.tag = ur ? "R6" : "R4"; end
            default: begin
               m = n % 32; e.tag = "R7";
               if (m != 0) begin e.res = (x >> m) | (x << (32 - m)); e.c = x[m-1]; end
               else begin e.res = x; e.c = x[31]; end
            end
         endcase
      end
      e.n  = e.res[31];
      e.z  = (e.res == 0);
      e.v  = vi;
      e.we = {2'b11, (n != 0), 1'b0};
      return e;
   endfunction

   task automatic drive(input logic [1:0] k, input bit ur, input logic [4:0] im,
                        input logic [7:0] ra, input logic [31:0] x, input bit ci, input bit vi);
      @(posedge clk);
      #1;
      kind = k; use_reg = ur; imm = im; ramt = ra; opnd = x; cin = ci; vin = vi;
      sb.push_back(predict(k, ur, im, ra, x, ci, vi));
   endtask

   // monitor: compare on the falling edge after each drive
   initial begin
      forever begin
         @(negedge clk);
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (result !== e.res || cout !== e.c) begin
               errors++;
               $display("FAIL %s: kind=%0d reg=%0d imm=%0d ramt=%0d x=%h res=%h c=%b exp res=%h c=%b",
                        e.tag, kind, use_reg, imm, ramt, opnd, result, cout, e.res, e.c);
            end
            checks++;
            if (neg !== e.n || zero !== e.z || vout !== e.v || we !== e.we) begin
               errors++;
               $display("FAIL R8: n=%b z=%b v=%b we=%b exp n=%b z=%b v=%b we=%b",
                        neg, zero, vout, we, e.n, e.z, e.v, e.we);
            end
         end
      end
   end

   initial begin
      logic [31:0] ops [5];
      logic [7:0]  ramts [6];
      logic [4:0]  imms [4];
      ops   = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hFFFF_FFFF, 32'h0000_0000, 32'hA5C3_0F96};
      ramts = '{8'd0, 8'd1, 8'd31, 8'd32, 8'd33, 8'd255};
      imms  = '{5'd0, 5'd1, 5'd17, 5'd31};
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // reset state: all-zero inputs, R1 no-op
      drive(2'd0, 1'b0, 5'd0, 8'd0, 32'h0, 1'b0, 1'b0);
      for (int k = 0; k < 4; k++)
         for (int o = 0; o < 5; o++)
            for (int c = 0; c < 2; c++) begin
               for (int a = 0; a < 6; a++)
                  drive(2'(k), 1'b1, 5'd0, ramts[a], ops[o], c[0], a[0]);
               for (int a = 0; a < 4; a++)
                  drive(2'(k), 1'b0, imms[a], 8'd0, ops[o], c[0], a[1]);
            end
      // register ROR by 64 and 96: nonzero multiples of the word (R7)
      drive(2'd3, 1'b1, 5'd0, 8'd64, 32'h0000_0001, 1'b1, 1'b0);
      drive(2'd3, 1'b1, 5'd0, 8'd96, 32'h8000_0000, 1'b0, 1'b1);
      // immediate field ignored in register form (R1): reg 0 with imm 9
      drive(2'd1, 1'b1, 5'd9, 8'd0, 32'h1234_5678, 1'b1, 1'b0);
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish, got hang exp completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule